// File: doc/BRIEF.md
# Ring-buffer sample capture memory

This block records the digitized samples of one acquisition channel into a circular store that never takes an address from outside. Samples arrive two per memory clock, an even lane and an odd lane, because the store is clocked at half the sample rate. A free-running position counter, which only advances on cycles that carry a valid pair, decides where each pair lands. When the counter passes the last position it wraps to zero and the store is marked as filled.

Capture is armed by a one-cycle pulse. A trigger request carries the number of further sample pairs to keep. Once that many pairs have landed after the trigger cycle, writing stops and the next write position is frozen as the stop pointer. A processor then pulls the record out one 8-bit sample per read strobe, slowly and oldest first. Re-arming starts a fresh capture at position zero and clears the filled and stopped state. The stored words are left as they are.

The controller is a six-state machine. `ST_IDLE` waits for the first arm. `ST_PRE` writes pre-trigger pairs. `ST_POST` counts down the post-trigger pairs. `ST_LATCH` is a single cycle that freezes the stop pointer and loads the read sequencer. `ST_READ` serves strobes. `ST_DONE` holds after the last valid sample. Transitions:
- arm: any state to `ST_PRE`.
- trigger with a zero count: `ST_PRE` to `ST_LATCH`.
- trigger with a non-zero count: `ST_PRE` to `ST_POST`.
- last post pair: `ST_POST` to `ST_LATCH`.
- record non-empty: `ST_LATCH` to `ST_READ`.
- record empty: `ST_LATCH` to `ST_DONE`.
- last sample read: `ST_READ` to `ST_DONE`.

`DEPTH` must be even.

Top module: `ring_capture_mem`

## Requirements
- R1: After reset the block is idle: `capturing`, `buf_full`, `rd_done` and `rd_ack` are 0 and `stop_pos` is 0.
- R2: A one-cycle `arm` in any state restarts capture. In the next cycle `capturing` is 1, `buf_full` is 0 and `stop_pos` is 0, and the next valid pair is written at pair position 0. The arm cycle itself writes nothing.
- R3: While capturing, each cycle with `smp_valid` high writes `smp_even` to sample position 2p and `smp_odd` to 2p+1, where p is the pair position. p then advances by one and wraps from DEPTH/2-1 to 0, so sample position DEPTH-1 is followed by 0. Cycles with `smp_valid` low write nothing.
- R4: `buf_full` rises on the first wrap of the pair position and stays high until the next arm.
- R5: A `trig` seen in the pre-trigger phase loads `trig_post` as a count N of sample pairs. The pair written in the trigger cycle is kept, exactly N further valid pairs are then written, and `capturing` falls. With N = 0, capture stops after the trigger cycle. A `trig` when idle, already counting down, or stopped has no effect.
- R6: Once capture has stopped, `stop_pos` equals the pair position the next write would have used, and sample inputs and triggers are ignored until the next arm.
- R7: In the read phase, each `rd_stb` cycle produces `rd_ack` = 1 in the following cycle, with the next sample on `rd_data`. Samples come oldest first, even lane before odd lane within a pair. Reading starts at pair `stop_pos` when `buf_full` is 1 and at pair 0 otherwise.
- R8: A record holds DEPTH samples when `buf_full` is 1 and 2·`stop_pos` samples otherwise. `rd_done` rises in the cycle that acknowledges the last sample, or right after the stop when the record is empty. Strobes outside the read phase give no `rd_ack`.
- R9: `capturing` and `rd_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock (one sample pair per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse starting a new capture |
| smp_valid | input | 1 | Sample pair present this cycle |
| smp_even | input | W | Even-lane sample |
| smp_odd | input | W | Odd-lane sample |
| trig | input | 1 | Trigger request |
| trig_post | input | POST_W | Post-trigger count in sample pairs, read with `trig` |
| rd_stb | input | 1 | Read strobe from the processor side |
| rd_data | output | W | Sample returned for the previous strobe |
| rd_ack | output | 1 | `rd_data` is valid this cycle |
| rd_done | output | 1 | All valid samples have been read |
| capturing | output | 1 | Writing is active (pre- or post-trigger) |
| buf_full | output | 1 | The ring has wrapped at least once since arm |
| stop_pos | output | $clog2(DEPTH/2) | Pair position after the last written pair |

## Verification
The properties rely on several things about the inputs:
- `arm` is a single-cycle pulse, and a trigger that coincides with it is overridden.
- `rd_stb` is a one-cycle pulse, so each acknowledgement can be traced back to exactly one strobe.
- `trig_post` only matters in the cycle where `trig` is high.

The stimulus drives `arm` alone, with valid data and trigger low. It gives every read strobe a one-cycle width with random idle gaps. It draws gaps in the sample stream, trigger positions and post counts from a seeded generator, and adds directed cases:
- an empty record;
- a trigger with a zero count;
- a capture that ends exactly on the wrap;
- a capture that wraps well past the end.

// File: rtl/ringcap_pkg.sv
package ringcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_LATCH,
        ST_READ,
        ST_DONE
    } cap_state_e;

endpackage

// File: rtl/ringcap_pos.sv
// Free-running pair position counter with first-wrap flag.
module ringcap_pos #(
    parameter int PAIRS = 4000,
    parameter int PTR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [PTR_W-1:0] pos,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(PAIRS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            full <= 1'b0;
        end else if (clr) begin
            pos  <= '0;
            full <= 1'b0;
        end else if (adv) begin
            if (pos == LAST) begin
                pos  <= '0;
                full <= 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ringcap_post.sv
// Post-trigger pair countdown.
module ringcap_post #(
    parameter int POST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [POST_W-1:0] load_val,
    input  logic              dec,
    output logic              is_last
);
    logic [POST_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_last = (cnt_q == POST_W'(1));
endmodule

// File: rtl/ringcap_rdptr.sv
// Sequential readout pointer: pair index, lane and samples left.
module ringcap_rdptr #(
    parameter int PAIRS = 4000,
    parameter int PTR_W = 12,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] start_pos,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             step,
    output logic [PTR_W-1:0] pos,
    output logic             lane,
    output logic [CNT_W-1:0] left
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(PAIRS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            lane <= 1'b0;
            left <= '0;
        end else if (load) begin
            pos  <= start_pos;
            lane <= 1'b0;
            left <= start_cnt;
        end else if (step) begin
            left <= left - 1'b1;
            if (lane) begin
                lane <= 1'b0;
                pos  <= (pos == LAST) ? '0 : pos + 1'b1;
            end else begin
                lane <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ringcap_store.sv
// Two-lane sample store: one pair per write, one lane per read.
module ringcap_store #(
    parameter int PAIRS = 4000,
    parameter int PTR_W = 12,
    parameter int W     = 8,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [LANES*W-1:0] wdata,
    input  logic               re,
    input  logic [PTR_W-1:0]   raddr,
    input  logic               rlane,
    output logic [W-1:0]       rdata
);
    logic [LANES*W-1:0] words;
    logic               sel_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] mem [PAIRS];
        logic [W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wdata[g*W +: W];
            end
            if (re) begin
                word_q <= mem[raddr];
            end
        end

        assign words[g*W +: W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (re) begin
            sel_q <= rlane;
        end
    end

    assign rdata = words[sel_q*W +: W];
endmodule

// File: rtl/ring_capture_mem.sv
// Ring-buffer capture memory: controller and top level.
module ring_capture_mem
    import ringcap_pkg::*;
#(
    parameter  int DEPTH  = 8000,
    parameter  int W      = 8,
    parameter  int POST_W = 16,
    localparam int PAIRS  = DEPTH / 2,
    localparam int PTR_W  = $clog2(PAIRS),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [W-1:0]      smp_even,
    input  logic [W-1:0]      smp_odd,
    input  logic              trig,
    input  logic [POST_W-1:0] trig_post,
    input  logic              rd_stb,
    output logic [W-1:0]      rd_data,
    output logic              rd_ack,
    output logic              rd_done,
    output logic              capturing,
    output logic              buf_full,
    output logic [PTR_W-1:0]  stop_pos
);
    cap_state_e       state_q, state_d;
    logic             wr_en;
    logic [PTR_W-1:0] wr_pos;
    logic             post_last;
    logic             trig_take;
    logic             rd_take;
    logic             rd_last;
    logic [PTR_W-1:0] rd_pos;
    logic             rd_lane;
    logic [CNT_W-1:0] rd_left;
    logic [PTR_W-1:0] rd_start;
    logic [CNT_W-1:0] rd_count;
    logic             rd_load;

    // Decoded controls
    assign capturing = (state_q == ST_PRE) || (state_q == ST_POST);
    assign rd_done   = (state_q == ST_DONE);
    assign wr_en     = capturing && smp_valid && !arm;
    assign trig_take = (state_q == ST_PRE) && trig && !arm;
    assign rd_take   = (state_q == ST_READ) && rd_stb && !arm;
    assign rd_last   = (rd_left == CNT_W'(1));
    assign rd_load   = (state_q == ST_LATCH) && !arm;
    assign rd_start  = buf_full ? wr_pos : '0;
    assign rd_count  = buf_full ? CNT_W'(DEPTH) : CNT_W'({wr_pos, 1'b0});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = ST_PRE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_PRE: begin
                    if (trig) begin
                        state_d = (trig_post == '0) ? ST_LATCH : ST_POST;
                    end
                end
                ST_POST: begin
                    if (smp_valid && post_last) begin
                        state_d = ST_LATCH;
                    end
                end
                ST_LATCH: state_d = (rd_count == '0) ? ST_DONE : ST_READ;
                ST_READ: begin
                    if (rd_stb && rd_last) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack   <= 1'b0;
            stop_pos <= '0;
        end else begin
            rd_ack <= rd_take;
            if (arm) begin
                stop_pos <= '0;
            end else if (state_q == ST_LATCH) begin
                stop_pos <= wr_pos;
            end
        end
    end

    ringcap_pos #(
        .PAIRS (PAIRS),
        .PTR_W (PTR_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .adv   (wr_en),
        .pos   (wr_pos),
        .full  (buf_full)
    );

    ringcap_post #(
        .POST_W (POST_W)
    ) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trig_take),
        .load_val (trig_post),
        .dec      ((state_q == ST_POST) && smp_valid && !arm),
        .is_last  (post_last)
    );

    ringcap_rdptr #(
        .PAIRS (PAIRS),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_rdptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_load),
        .start_pos (rd_start),
        .start_cnt (rd_count),
        .step      (rd_take),
        .pos       (rd_pos),
        .lane      (rd_lane),
        .left      (rd_left)
    );

    ringcap_store #(
        .PAIRS (PAIRS),
        .PTR_W (PTR_W),
        .W     (W),
        .LANES (2)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_pos),
        .wdata ({smp_odd, smp_even}),
        .re    (rd_take),
        .raddr (rd_pos),
        .rlane (rd_lane),
        .rdata (rd_data)
    );
endmodule

// File: rtl/ringcap_chk.sv
// Property checker bound to the capture memory.
module ringcap_chk
    import ringcap_pkg::*;
#(
    parameter int PAIRS  = 4000,
    parameter int PTR_W  = 12,
    parameter int POST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              trig,
    input logic [POST_W-1:0] trig_post,
    input logic              rd_stb,
    input logic              rd_ack,
    input logic              rd_done,
    input logic              capturing,
    input logic              buf_full,
    input logic              wr_en,
    input logic [PTR_W-1:0]  wr_pos,
    input cap_state_e        state
);
    assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_pos) < PAIRS);

    assert_arm_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (capturing && !buf_full && wr_pos == '0));

    assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !arm) |=> buf_full);

    assert_post_zero_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE && trig && trig_post == '0 && !arm) |=> !capturing);

    assert_no_write_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capturing |-> !wr_en);

    assert_ack_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(rd_stb));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !arm) |=> (rd_done && !rd_ack));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capturing, rd_done}));
endmodule

bind ring_capture_mem ringcap_chk #(
    .PAIRS  (PAIRS),
    .PTR_W  (PTR_W),
    .POST_W (POST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .trig      (trig),
    .trig_post (trig_post),
    .rd_stb    (rd_stb),
    .rd_ack    (rd_ack),
    .rd_done   (rd_done),
    .capturing (capturing),
    .buf_full  (buf_full),
    .wr_en     (wr_en),
    .wr_pos    (wr_pos),
    .state     (state_q)
);

// File: tb/tb_ring_capture_mem.sv
module tb_ring_capture_mem;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8000;
    localparam int PAIRS  = DEPTH / 2;
    localparam int W      = 8;
    localparam int POST_W = 16;
    localparam int PTR_W  = $clog2(PAIRS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0;
    logic              smp_valid = 1'b0;
    logic [W-1:0]      smp_even = '0;
    logic [W-1:0]      smp_odd = '0;
    logic              trig = 1'b0;
    logic [POST_W-1:0] trig_post = '0;
    logic              rd_stb = 1'b0;
    logic [W-1:0]      rd_data;
    logic              rd_ack;
    logic              rd_done;
    logic              capturing;
    logic              buf_full;
    logic [PTR_W-1:0]  stop_pos;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_capture_mem #(
        .DEPTH  (DEPTH),
        .W      (W),
        .POST_W (POST_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_even  (smp_even),
        .smp_odd   (smp_odd),
        .trig      (trig),
        .trig_post (trig_post),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .rd_ack    (rd_ack),
        .rd_done   (rd_done),
        .capturing (capturing),
        .buf_full  (buf_full),
        .stop_pos  (stop_pos)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Reference model of the ring
    logic [W-1:0] m_even [PAIRS];
    logic [W-1:0] m_odd  [PAIRS];
    int m_wp   = 0;
    bit m_full = 1'b0;
    bit m_cap  = 1'b0;
    bit m_post = 1'b0;
    int m_left = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One memory clock of sample stimulus; starts and ends at a falling edge.
    task automatic step(input bit v, input bit t, input int post);
        logic [W-1:0] e;
        logic [W-1:0] o;
        e = W'($urandom);
        o = W'($urandom);
        smp_valid = v;
        smp_even  = e;
        smp_odd   = o;
        trig      = t;
        trig_post = POST_W'(post);
        @(posedge clk);
        if (m_cap && v) begin
            m_even[m_wp] = e;
            m_odd[m_wp]  = o;
            if (m_wp == PAIRS - 1) begin
                m_wp   = 0;
                m_full = 1'b1;
            end else begin
                m_wp++;
            end
        end
        if (m_cap) begin
            if (!m_post && t) begin
                if (post == 0) m_cap = 1'b0;
                else begin
                    m_post = 1'b1;
                    m_left = post;
                end
            end else if (m_post && v) begin
                m_left--;
                if (m_left == 0) m_cap = 1'b0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        trig      = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(posedge clk);
        m_wp = 0; m_full = 1'b0; m_cap = 1'b1; m_post = 1'b0;
        @(negedge clk);
        arm = 1'b0;
        chk(capturing == 1'b1, "R2", "capturing after arm", int'(capturing), 1);
        chk(buf_full == 1'b0, "R2", "buf_full after arm", int'(buf_full), 0);
        chk(stop_pos == '0, "R2", "stop_pos after arm", int'(stop_pos), 0);
    endtask

    task automatic run_until_stop();
        while (m_cap) step($urandom_range(0, 3) != 0, 1'b0, 0);
    endtask

    task automatic read_all();
        int n;
        int start;
        repeat (3) @(negedge clk);
        chk(capturing == 1'b0, "R5", "capturing after stop", int'(capturing), 0);
        chk(int'(stop_pos) == m_wp, "R6", "stop_pos", int'(stop_pos), m_wp);
        chk(buf_full == m_full, "R4", "buf_full", int'(buf_full), int'(m_full));
        n     = m_full ? DEPTH : 2 * m_wp;
        start = m_full ? m_wp : 0;
        chk(rd_done == (n == 0), "R8", "rd_done before reading", int'(rd_done), int'(n == 0));
        for (int i = 0; i < n; i++) begin
            int p;
            logic [W-1:0] exp;
            p   = (start + i / 2) % PAIRS;
            exp = (i % 2 == 1) ? m_odd[p] : m_even[p];
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            chk(rd_ack == 1'b1, "R7", "rd_ack", int'(rd_ack), 1);
            chk(rd_data == exp, "R7", "rd_data oldest first", int'(rd_data), int'(exp));
            chk(rd_done == (i == n - 1), "R8", "rd_done timing", int'(rd_done), int'(i == n - 1));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(rd_ack == 1'b0, "R8", "strobe after last", int'(rd_ack), 0);
        chk(rd_done == 1'b1, "R8", "rd_done held", int'(rd_done), 1);
    endtask

    initial begin
        repeat (CLK_PERIOD * 19000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(capturing == 1'b0, "R1", "capturing", int'(capturing), 0);
        chk(buf_full == 1'b0, "R1", "buf_full", int'(buf_full), 0);
        chk(rd_done == 1'b0, "R1", "rd_done", int'(rd_done), 0);
        chk(rd_ack == 1'b0, "R1", "rd_ack", int'(rd_ack), 0);
        chk(stop_pos == '0, "R1", "stop_pos", int'(stop_pos), 0);

        // R5: trigger and samples while idle do nothing; R8: strobe while idle
        repeat (3) step(1'b1, 1'b1, 0);
        chk(capturing == 1'b0, "R5", "trigger while idle", int'(capturing), 0);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(rd_ack == 1'b0, "R8", "strobe while idle", int'(rd_ack), 0);

        // R2/R3/R5/R6: restart mid-capture, trigger with post count, late inputs ignored
        do_arm();
        repeat (5) step(1'b1, 1'b0, 0);
        do_arm();
        repeat (10) step($urandom_range(0, 3) != 0, 1'b0, 0);
        step(1'b1, 1'b1, 3);
        step(1'b1, 1'b1, 0);  // trigger while counting down: ignored
        run_until_stop();
        repeat (4) step(1'b1, 1'b1, 2);  // after stop: ignored
        read_all();

        // R5: trigger with zero count and a pair in the same cycle
        do_arm();
        step(1'b1, 1'b1, 0);
        read_all();

        // R8: empty record
        do_arm();
        step(1'b0, 1'b1, 0);
        read_all();

        // R3/R4: capture ending exactly on the wrap
        do_arm();
        repeat (PAIRS - 1) step(1'b1, 1'b0, 0);
        chk(buf_full == 1'b0, "R4", "not full before wrap", int'(buf_full), 0);
        step(1'b1, 1'b1, 0);
        read_all();

        // R3/R4/R7: capture wrapping well past the end
        do_arm();
        repeat (4500) step($urandom_range(0, 4) != 0, 1'b0, 0);
        step(1'b1, 1'b1, 700);
        run_until_stop();
        read_all();

        // Random short captures
        for (int r = 0; r < 6; r++) begin
            do_arm();
            repeat ($urandom_range(0, 40)) step($urandom_range(0, 2) != 0, 1'b0, 0);
            step($urandom_range(0, 1) == 1, 1'b1, $urandom_range(0, 20));
            run_until_stop();
            read_all();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule